// File: doc/BRIEF.md
# Wait-State Parallel Read Sequencer

This block lets a synchronous host issue single 16-bit reads to a device on an asynchronous parallel bus that has a chip-select strobe, a read-enable strobe and a word address. The host offers a word address on a valid/ready handshake. The sequencer puts the address on the bus and pulls both strobes low together. It holds them low long enough to meet both the minimum strobe-low time and the device's worst-case data delay. On the last low clock it captures the data bus. It then raises the strobes and returns the captured word with a one-clock valid pulse.

After that it keeps the strobes high long enough to meet both the minimum high time and the minimum total read cycle. Only then does it accept another request. All limits are given in nanoseconds as parameters, together with the clock period. The sequencer turns them into clock counts when it is elaborated, rounding up. If the low and high counts together fall short of the cycle count, the high phase is lengthened.

Top module: `pio_read_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle with both strobes high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `bus_addr` then carries the request address and stays stable for as long as the strobes are low.
- R2: `bus_cs_n` and `bus_rd_n` are always equal. They fall in the first clock after a request is taken.
- R3: The strobes stay low for exactly LOW_CLKS clocks. LOW_CLKS is the largest of ceil(T_LOW_NS/CLK_PERIOD_NS), ceil(T_DATA_NS/CLK_PERIOD_NS) and 2. With the defaults (5 ns clock, 32 ns low, 30 ns data delay) this is 7.
- R4: `rsp_data` is the value of `bus_data` sampled at the clock edge that ends the last low clock. With the defaults this is 7 clocks after the strobes fall, which is later than the 6 clocks the device may need to drive valid data.
- R5: `rsp_valid` is high for exactly one clock, and that clock is the first clock in which the strobes are high again.
- R6: Between two low phases the strobes stay high for at least ceil(T_HIGH_NS/CLK_PERIOD_NS) clocks, which is 3 with the defaults.
- R7: From one strobe fall to the next there are at least ceil(T_CYCLE_NS/CLK_PERIOD_NS) clocks, which is 33 with the defaults. The high phase is stretched to make this true. With requests waiting back to back, the high phase lasts exactly HIGH_CLKS = max(33 − 7, 3, 2) = 26 clocks.
- R8: While `rst_n` is low, `req_ready` is high, both strobes are high and `rsp_valid` is low.
- R9: A request held on `req_valid` while a read is in progress is not taken until the sequencer is idle. Exactly one bus read happens for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a read request |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-clock pulse: `rsp_data` holds the read word |
| rsp_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address driven to the device |
| bus_cs_n | output | 1 | Chip-select strobe, active low |
| bus_rd_n | output | 1 | Read-enable strobe, active low |
| bus_data | input | DATA_W | Data driven by the device |

## Verification
The device model in the bench drives a garbage word until the worst-case data delay has passed after the strobe fall, and only then the address-derived word. A sequencer that samples one clock early therefore returns garbage and fails the scoreboard. The bench measures every low and high phase and keeps the smallest high phase seen under back-to-back requests. This catches a low phase that is too short or too long, and a high phase that is not stretched to fill the cycle minimum. A request held valid through a busy read would show up as an extra bus cycle or a duplicated response. A response pulse placed off the strobe rise, or lasting two clocks, is also reported.

// File: rtl/pio_read_seq.sv
module pio_read_seq #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int ADDR_W        = 7,
  parameter int DATA_W        = 16,
  parameter int T_CYCLE_NS    = 165,
  parameter int T_LOW_NS      = 32,
  parameter int T_HIGH_NS     = 13,
  parameter int T_DATA_NS     = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  input  logic [DATA_W-1:0] bus_data
);

  function automatic int clocks_for(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LOW_CLKS  = max2(max2(clocks_for(T_LOW_NS), clocks_for(T_DATA_NS)), 2);
  localparam int CYC_CLKS  = clocks_for(T_CYCLE_NS);
  localparam int HIGH_MIN  = max2(clocks_for(T_HIGH_NS), 2);
  localparam int HIGH_CLKS = max2(HIGH_MIN, CYC_CLKS - LOW_CLKS);
  localparam int CNT_W     = $clog2(max2(LOW_CLKS, HIGH_CLKS) + 1);

  typedef enum logic [1:0] {IDLE, ASSERT, SAMPLE, DEASSERT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             strobe_n;
  logic             take;

  assign req_ready = (state == IDLE);
  assign take      = req_valid && req_ready;
  assign bus_cs_n  = strobe_n;
  assign bus_rd_n  = strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      strobe_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      bus_addr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        IDLE: if (take) begin
          bus_addr <= req_addr;
          strobe_n <= 1'b0;
          cnt      <= CNT_W'(LOW_CLKS - 2);
          state    <= ASSERT;
        end
        ASSERT: begin
          if (cnt == '0) state <= SAMPLE;
          else           cnt   <= cnt - 1'b1;
        end
        SAMPLE: begin
          rsp_data  <= bus_data;
          rsp_valid <= 1'b1;
          strobe_n  <= 1'b1;
          cnt       <= CNT_W'(HIGH_CLKS - 2);
          state     <= DEASSERT;
        end
        DEASSERT: begin
          if (cnt == '0) state <= IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n);

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  assert_fall_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_cs_n && !bus_rd_n));

  assert_fall_needs_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> $past(req_valid && req_ready));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_pulse_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(bus_cs_n));

endmodule

// File: tb/pio_read_seq_bench.sv
module pio_read_seq_bench;
  localparam int AW = 7, DW = 16;
  localparam int EXP_LOW = 7, EXP_HIGH = 26, EXP_CYC = 33, MIN_HIGH = 3, DATA_CLKS = 6;

  logic clk = 0, rst_n = 0, req_valid = 0, req_ready, rsp_valid, bus_cs_n, bus_rd_n;
  logic [AW-1:0] req_addr = '0, bus_addr;
  logic [DW-1:0] rsp_data, bus_data;
  int tests = 0, fails = 0;
  logic [DW-1:0] expq[$];
  int pushes = 0, falls = 0, responses = 0;

  always #2.5 clk = ~clk;

  pio_read_seq u_pio_read_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_data(bus_data));

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {~a, 2'b10, a};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model: garbage until the data delay has elapsed
  int lc = 0;
  always @(posedge clk) begin
    if (bus_cs_n) begin
      lc <= 0;
      bus_data <= 16'hBAD0;
    end else begin
      lc <= lc + 1;
      bus_data <= (lc + 1 >= DATA_CLKS) ? word_of(bus_addr) : 16'hBAD0;
    end
  end

  // monitor
  logic prev_cs = 1'b1, prev_rv = 1'b0;
  logic [AW-1:0] low_addr;
  int low_run = 0, high_run = 0, last_low = 0, min_high = 1000;
  bit seen_low = 0;
  always @(negedge clk) if (rst_n) begin
    if (bus_cs_n != bus_rd_n) check(0, "R2 strobes differ", bus_cs_n, bus_rd_n);
    if (!bus_cs_n && prev_cs) begin
      falls++;
      low_addr = bus_addr;
      if (seen_low) begin
        check(high_run >= MIN_HIGH, "R6 high time", high_run, MIN_HIGH);
        check(high_run + last_low >= EXP_CYC, "R7 cycle time", high_run + last_low, EXP_CYC);
        if (high_run < min_high) min_high = high_run;
      end
      low_run = 1;
    end else if (!bus_cs_n) begin
      low_run++;
      if (bus_addr != low_addr) check(0, "R1 addr stable", bus_addr, low_addr);
    end else if (bus_cs_n && !prev_cs) begin
      check(low_run == EXP_LOW, "R3 low length", low_run, EXP_LOW);
      check(rsp_valid == 1'b1, "R5 valid at rise", rsp_valid, 1);
      last_low = low_run; seen_low = 1; high_run = 1;
    end else high_run++;
    if (!req_ready && !prev_cs && bus_cs_n) ; // ready low through read is covered by R9 counts
    if (req_ready && !bus_cs_n) check(0, "R1 ready while busy", req_ready, 0);
    if (rsp_valid) begin
      responses++;
      check(!prev_rv, "R5 one-clock pulse", prev_rv, 0);
      if (expq.size() == 0) check(0, "R9 unexpected response", rsp_data, 0);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        check(rsp_data == e, "R4 read data", rsp_data, e);
      end
    end
    prev_cs = bus_cs_n;
    prev_rv = rsp_valid;
  end

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic do_read(input logic [AW-1:0] a);
    req_valid = 1; req_addr = a;
    while (!req_ready) @(negedge clk);
    expq.push_back(word_of(a));
    pushes++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(req_ready && bus_cs_n && bus_rd_n && !rsp_valid, "R8 reset state",
              {req_ready, bus_cs_n, bus_rd_n, rsp_valid}, 4'b1110);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && bus_cs_n, "R8 after reset", {req_ready, bus_cs_n}, 2'b11);
        do_read(7'h00);
        idle(50);
        do_read(7'h7F);
        idle(3);
        do_read(7'h55);   // R9: held valid while busy
        do_read(7'h2A);
        do_read(7'h13);
        do_read(7'h6C);
        idle(60);
        check(min_high == EXP_HIGH, "R7 back-to-back high", min_high, EXP_HIGH);
        check(falls == pushes, "R9 one bus read per request", falls, pushes);
        check(responses == pushes && expq.size() == 0, "R4 all responses", responses, pushes);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule